// File: doc/BRIEF.md
# Software SCI Trigger Register

This block is a small configuration-space register pair. It lets host software raise a system control interrupt (SCI) event toward an I/O hub. One register, the event register, holds a source-select bit and a trigger bit. When software writes the trigger bit from 0 to 1 and the select bit already chooses SCI, the block queues exactly one event message. The message waits on an outbound valid/ready port until the link takes it. A second register, the SMI request register, holds a plain trigger bit. That bit fires a one-cycle SMI request pulse, but only while the select bit chooses SMI.

The trigger bits do not clear themselves. Once written to 1, a trigger bit stays 1, and software must write 0 to it before it can fire again. Only one SCI message can be outstanding at a time. If a second qualifying trigger arrives while the link still holds back the first message, the block keeps only one message pending and raises a sticky drop flag. Both registers can be read back through a configuration-read port with one cycle of latency.

Top module: `soft_sci_trigger`

## Requirements
- R1: Reset clears the select bit, both trigger bits, any pending SCI message and the drop flag. After reset, `sci_msg_valid`, `smi_req` and `sci_drop` are 0 and both registers read 0.
- R2: The event register sits at offset 0xE8. Bit 15 is the source select, where 1 means SCI. Bit 0 is the SCI trigger. Bit 15 takes the written value on every write to 0xE8. All other bits read 0 and ignore writes.
- R3: A write to 0xE8 with data bit 0 = 1, while stored bit 0 is 0 and the stored select bit is 1, raises `sci_msg_valid` after the clock edge that takes the write. It causes exactly one message. The select bit is judged by its value before the write.
- R4: Writes to 0xE8 that move bit 0 from 1 to 1, from 1 to 0 or from 0 to 0 produce no message. A 1-to-0 write clears stored bit 0 when the select bit is 1.
- R5: While the stored select bit is 0, writes to 0xE8 leave bit 0 unchanged and produce no message.
- R6: Stored bit 0 of 0xE8 stays 1 until software writes 0 to it. Writing 1 again does not fire again.
- R7: `sci_msg_valid` stays high until a clock edge where `sci_msg_ready` is high. It then falls, unless a new qualifying trigger lands on that same edge. In that case the new message becomes pending and no drop is flagged.
- R8: A qualifying trigger that arrives while a message is pending and `sci_msg_ready` is low is merged with it. Only one message remains pending, and `sci_drop` goes to 1 and stays 1 until reset.
- R9: The SMI request register sits at offset 0xE0, with bit 0 as its trigger. While the select bit is 0, a 0-to-1 write to bit 0 gives a one-cycle `smi_req` pulse after the write edge. Other writes give no pulse, and the bit reads back as written. While the select bit is 1, writes to 0xE0 are ignored.
- R10: A read strobe presents the register contents on `cfg_rd_data` after the next clock edge. An offset other than 0xE0 or 0xE8 reads 0, and `cfg_rd_data` is 0 in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | 8 | Configuration write offset |
| cfg_wr_data | input | 32 | Configuration write data |
| cfg_rd_en | input | 1 | Configuration read strobe |
| cfg_rd_addr | input | 8 | Configuration read offset |
| cfg_rd_data | output | 32 | Read data, one cycle after the strobe |
| sci_msg_valid | output | 1 | SCI event message pending on the outbound link |
| sci_msg_ready | input | 1 | Link accepts the pending message |
| smi_req | output | 1 | One-cycle SMI request pulse |
| sci_drop | output | 1 | Sticky flag: a trigger was merged into a pending message |

## Verification
The assertions check the following on every cycle:
- a pending message is held until the link accepts it;
- the drop flag is sticky;
- a trigger that meets a blocked message sets the drop flag;
- a stored trigger bit stays 1 without an explicit clear;
- writes blocked by the select bit leave the trigger bits unchanged;
- a new message can only start from a set select bit;
- unmapped reads return zero.

Only the bench scenarios can show that the number of messages equals the number of qualifying 0-to-1 writes. The bench's scoreboard counts each accepted handshake against the expected triggers. The scenarios also cover:
- a trigger that lands on the same edge as an acceptance, which gives a second message and no drop;
- merging under back-pressure;
- the way the select bit steers writes between the two registers.

// File: rtl/swsci_pkg.sv
package swsci_pkg;

    localparam int CFG_AW = 8;
    localparam int CFG_DW = 32;

    localparam logic [CFG_AW-1:0] EVT_OFS = 8'hE8;
    localparam logic [CFG_AW-1:0] SMI_OFS = 8'hE0;

    localparam int TRIG_POS = 0;
    localparam int SEL_POS  = 15;

    typedef enum logic [1:0] {
        HIT_NONE = 2'd0,
        HIT_EVT  = 2'd1,
        HIT_SMI  = 2'd2
    } reg_hit_e;

    // Decode an offset into one of the two registers.
    function automatic reg_hit_e decode_ofs(input logic [CFG_AW-1:0] ofs);
        if (ofs == EVT_OFS)      return HIT_EVT;
        else if (ofs == SMI_OFS) return HIT_SMI;
        else                     return HIT_NONE;
    endfunction

    // A write qualifies only when enabled and it moves the bit from 0 to 1.
    function automatic logic rising_write(input logic stored,
                                          input logic written,
                                          input logic allow);
        return allow && !stored && written;
    endfunction

    // Build the read-back word of the event register.
    function automatic logic [CFG_DW-1:0] evt_word(input logic sel, input logic trig);
        logic [CFG_DW-1:0] w;
        w = '0;
        w[SEL_POS]  = sel;
        w[TRIG_POS] = trig;
        return w;
    endfunction

    // Build the read-back word of the SMI request register.
    function automatic logic [CFG_DW-1:0] smi_word(input logic trig);
        logic [CFG_DW-1:0] w;
        w = '0;
        w[TRIG_POS] = trig;
        return w;
    endfunction

endpackage

// File: rtl/trig_bit_reg.sv
module trig_bit_reg (
    input  logic clk,
    input  logic rst,
    input  logic wr_hit,
    input  logic wr_bit,
    input  logic allow,
    output logic q,
    output logic fire
);
    import swsci_pkg::*;

    assign fire = wr_hit && rising_write(q, wr_bit, allow);

    always_ff @(posedge clk) begin
        if (rst)
            q <= 1'b0;
        else if (wr_hit && allow)
            q <= wr_bit;
    end

    // R5
    blocked_write_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_hit && allow) |=> $stable(q));

    // R6
    bit_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (q && !(wr_hit && allow && !wr_bit)) |=> q);

endmodule

// File: rtl/evt_slot.sv
module evt_slot (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic ready,
    output logic valid,
    output logic drop
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            drop  <= 1'b0;
        end else begin
            if (fire)
                valid <= 1'b1;
            else if (ready)
                valid <= 1'b0;
            if (fire && valid && !ready)
                drop <= 1'b1;
        end
    end

    // R7
    hold_until_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready) |=> valid);

    // R8
    drop_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        drop |=> drop);

    // R8
    merge_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready && fire) |=> (valid && drop));

endmodule

// File: rtl/soft_sci_trigger.sv
module soft_sci_trigger #(
    parameter int ADDR_W = swsci_pkg::CFG_AW,
    parameter int DATA_W = swsci_pkg::CFG_DW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_en,
    input  logic [ADDR_W-1:0] cfg_wr_addr,
    input  logic [DATA_W-1:0] cfg_wr_data,
    input  logic              cfg_rd_en,
    input  logic [ADDR_W-1:0] cfg_rd_addr,
    output logic [DATA_W-1:0] cfg_rd_data,
    output logic              sci_msg_valid,
    input  logic              sci_msg_ready,
    output logic              smi_req,
    output logic              sci_drop
);
    import swsci_pkg::*;

    reg_hit_e wr_hit, rd_hit;
    logic     evt_wr, smi_wr;
    logic     sel_q;
    logic     evt_trig_q, evt_fire;
    logic     smi_trig_q, smi_fire;
    logic     unused_wr_bits;

    assign wr_hit = cfg_wr_en ? decode_ofs(cfg_wr_addr) : HIT_NONE;
    assign rd_hit = decode_ofs(cfg_rd_addr);
    assign evt_wr = (wr_hit == HIT_EVT);
    assign smi_wr = (wr_hit == HIT_SMI);
    assign unused_wr_bits = ^{cfg_wr_data[DATA_W-1:SEL_POS+1], cfg_wr_data[SEL_POS-1:TRIG_POS+1]};

    // Source select: SCI when 1
    always_ff @(posedge clk) begin
        if (rst)
            sel_q <= 1'b0;
        else if (evt_wr)
            sel_q <= cfg_wr_data[SEL_POS];
    end

    trig_bit_reg u_evt_bit (
        .clk    (clk),
        .rst    (rst),
        .wr_hit (evt_wr),
        .wr_bit (cfg_wr_data[TRIG_POS]),
        .allow  (sel_q),
        .q      (evt_trig_q),
        .fire   (evt_fire)
    );

    trig_bit_reg u_smi_bit (
        .clk    (clk),
        .rst    (rst),
        .wr_hit (smi_wr),
        .wr_bit (cfg_wr_data[TRIG_POS]),
        .allow  (!sel_q),
        .q      (smi_trig_q),
        .fire   (smi_fire)
    );

    evt_slot u_slot (
        .clk   (clk),
        .rst   (rst),
        .fire  (evt_fire),
        .ready (sci_msg_ready),
        .valid (sci_msg_valid),
        .drop  (sci_drop)
    );

    always_ff @(posedge clk) begin
        if (rst)
            smi_req <= 1'b0;
        else
            smi_req <= smi_fire;
    end

    // Read-back path, one cycle latency
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_rd_data <= '0;
        end else if (cfg_rd_en) begin
            unique case (rd_hit)
                HIT_EVT: cfg_rd_data <= evt_word(sel_q, evt_trig_q);
                HIT_SMI: cfg_rd_data <= smi_word(smi_trig_q);
                default: cfg_rd_data <= '0;
            endcase
        end else begin
            cfg_rd_data <= '0;
        end
    end

    // R3
    msg_needs_sci_sel_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sci_msg_valid) |-> $past(sel_q));

    // R9
    smi_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        smi_req |=> !smi_req);

    // R9
    smi_needs_smi_sel_chk: assert property (@(posedge clk) disable iff (rst)
        smi_req |-> $past(!sel_q));

    // R10
    unmapped_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_rd_en && rd_hit == HIT_NONE) |=> (cfg_rd_data == '0));

endmodule

// File: tb/soft_sci_trigger_test.sv
module soft_sci_trigger_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_wr_addr = '0;
    logic [31:0] cfg_wr_data = '0;
    logic        cfg_rd_en = 1'b0;
    logic [7:0]  cfg_rd_addr = '0;
    logic [31:0] cfg_rd_data;
    logic        sci_msg_valid;
    logic        sci_msg_ready = 1'b1;
    logic        smi_req;
    logic        sci_drop;

    int errors = 0;
    int checks = 0;
    int exp_q[$];
    int next_id = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    soft_sci_trigger uut (
        .clk(clk), .rst(rst),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_en(cfg_rd_en), .cfg_rd_addr(cfg_rd_addr), .cfg_rd_data(cfg_rd_data),
        .sci_msg_valid(sci_msg_valid), .sci_msg_ready(sci_msg_ready),
        .smi_req(smi_req), .sci_drop(sci_drop)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Callers are at a negedge; drive now, release at the next negedge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic expect_msg();
        exp_q.push_back(next_id);
        next_id++;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        cfg_rd_en = 1'b1; cfg_rd_addr = a;
        @(negedge clk);
        cfg_rd_en = 1'b0;
        d = cfg_rd_data;
    endtask

    // Scoreboard monitor: each accepted handshake must match an expected trigger
    always @(posedge clk) begin
        if (!rst && sci_msg_valid && sci_msg_ready) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R3/R8 scoreboard: actual=unexpected message expected=none");
            end else begin
                void'(exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 valid", {31'b0, sci_msg_valid}, 32'd0);
        check("R1 smi", {31'b0, smi_req}, 32'd0);
        check("R1 drop", {31'b0, sci_drop}, 32'd0);
        rd(8'hE8, d); check("R1 evt reg", d, 32'h0);
        rd(8'hE0, d); check("R1 smi reg", d, 32'h0);

        // R5 select=0: trigger ignored
        wr(8'hE8, 32'h0000_0001);
        check("R5 no msg", {31'b0, sci_msg_valid}, 32'd0);
        rd(8'hE8, d); check("R5 bit0 unchanged", d, 32'h0);

        // R9 SMI register while select=0
        wr(8'hE0, 32'h1);
        check("R9 smi pulse", {31'b0, smi_req}, 32'd1);
        @(negedge clk);
        check("R9 smi one cycle", {31'b0, smi_req}, 32'd0);
        rd(8'hE0, d); check("R9 smi readback", d, 32'h1);
        wr(8'hE0, 32'h1);
        check("R9 1->1 no pulse", {31'b0, smi_req}, 32'd0);
        wr(8'hE0, 32'h0);
        rd(8'hE0, d); check("R9 smi cleared", d, 32'h0);

        // R2 select set, reserved bits dropped, bit0 blocked by old select
        wr(8'hE8, 32'hFFFF_FFFF);
        check("R2 no msg old sel", {31'b0, sci_msg_valid}, 32'd0);
        rd(8'hE8, d); check("R2 readback", d, 32'h0000_8000);

        // R9 SMI register ignored while select=1
        wr(8'hE0, 32'h1);
        check("R9 ignored pulse", {31'b0, smi_req}, 32'd0);
        rd(8'hE0, d); check("R9 ignored value", d, 32'h0);

        // R3 a 0->1 trigger gives one message
        sci_msg_ready = 1'b1;
        expect_msg();
        wr(8'hE8, 32'h0000_8001);
        check("R3 valid", {31'b0, sci_msg_valid}, 32'd1);
        @(negedge clk);
        check("R7 valid falls after accept", {31'b0, sci_msg_valid}, 32'd0);
        rd(8'hE8, d); check("R6 bit0 held", d, 32'h0000_8001);

        // R4 / R6 non-qualifying transitions
        wr(8'hE8, 32'h0000_8001);
        check("R6 1->1 no msg", {31'b0, sci_msg_valid}, 32'd0);
        wr(8'hE8, 32'h0000_8000);
        check("R4 1->0 no msg", {31'b0, sci_msg_valid}, 32'd0);
        rd(8'hE8, d); check("R4 cleared", d, 32'h0000_8000);
        wr(8'hE8, 32'h0000_8000);
        check("R4 0->0 no msg", {31'b0, sci_msg_valid}, 32'd0);

        // R7 hold under back-pressure, then trigger on the accepting edge
        sci_msg_ready = 1'b0;
        expect_msg();
        wr(8'hE8, 32'h0000_8001);
        for (int i = 0; i < 3; i++) begin
            check("R7 held", {31'b0, sci_msg_valid}, 32'd1);
            @(negedge clk);
        end
        wr(8'hE8, 32'h0000_8000);
        check("R7 still held", {31'b0, sci_msg_valid}, 32'd1);
        sci_msg_ready = 1'b1;
        expect_msg();
        wr(8'hE8, 32'h0000_8001);
        check("R7 new pending", {31'b0, sci_msg_valid}, 32'd1);
        check("R7 no drop", {31'b0, sci_drop}, 32'd0);
        @(negedge clk);
        check("R7 drained", {31'b0, sci_msg_valid}, 32'd0);

        // R8 merge while blocked
        sci_msg_ready = 1'b0;
        wr(8'hE8, 32'h0000_8000);
        expect_msg();
        wr(8'hE8, 32'h0000_8001);
        wr(8'hE8, 32'h0000_8000);
        wr(8'hE8, 32'h0000_8001);
        check("R8 drop set", {31'b0, sci_drop}, 32'd1);
        check("R8 one pending", {31'b0, sci_msg_valid}, 32'd1);
        sci_msg_ready = 1'b1;
        @(negedge clk);
        check("R8 single message", {31'b0, sci_msg_valid}, 32'd0);
        repeat (2) @(negedge clk);
        check("R8 drop sticky", {31'b0, sci_drop}, 32'd1);

        // R10 unmapped and idle reads
        rd(8'h10, d); check("R10 unmapped", d, 32'h0);
        @(negedge clk);
        check("R10 idle zero", cfg_rd_data, 32'h0);

        check("R3 scoreboard empty", exp_q.size(), 32'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule